// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Controller with CAS-before-RAS Refresh

This block sequences an asynchronous fast-page-mode DRAM array that has a multiplexed row/column address bus, one active-low row strobe, a pair of active-low column strobes driven in unison, and an active-low write enable. The host side is a plain request port. A request carries a write flag, a row, a column and write data, and is taken on a cycle where `req_valid_i` and `req_ready_o` are both high. Read data comes back on a one-cycle `rsp_valid_o` pulse.

After reset the controller keeps every strobe idle for a long power-up pause. It then runs a burst of CAS-before-RAS refresh cycles, and only after that does it raise `req_ready_o`. In normal operation a free-running interval timer raises a refresh request. The controller keeps a row open while the requests that follow hit that row. A request to another row costs a precharge and a fresh activation. A pending refresh has priority over new host work and closes the open page once the current column cycle ends. Every write is an early write: write enable falls together with the column strobes, and the data pins are driven only in that window.

All strobe timings are parameters counted in whole clock cycles. The defaults assume a 20 ns clock and the fastest speed grade.

Top module: `fpm_ctrl`

## Requirements
- R1: While reset is released and for the first `INIT_CYC` cycles after it, `dram_ras_no`=1, `dram_cas_no`=2'b11, `dram_we_no`=1, `dram_dq_oe_o`=0 and `req_ready_o`=0.
- R2: `req_ready_o` first rises only after exactly `INIT_REF` (8) CAS-before-RAS refresh cycles have been issued after the pause.
- R3: In a refresh, both column strobes are low for at least `T_CSR` cycles before `dram_ras_no` falls. `dram_we_no` is high in the cycle before that fall and in the cycle of it. The two column strobe bits are always equal.
- R4: After the start-up burst, successive refresh cycles start no more than `REF_INT` + 16 cycles apart, including while the host is idle with a page open.
- R5: `dram_ras_no` stays high for at least `T_RP` cycles between low periods. Each low period lasts at least `T_RAS` cycles and less than 5000 cycles (the page-open limit).
- R6: On an activation, `dram_addr_o` carries the request row when `dram_ras_no` falls. The column strobes fall no earlier than `T_RCD` cycles later, with the column on `dram_addr_o`.
- R7: A read holds the column strobes low for `T_CAS` cycles with `dram_we_no`=1 and `dram_dq_oe_o`=0. `dram_dq_i` is captured at the end of that window and returned on `rsp_rdata_o`, with `rsp_valid_o` high for one cycle.
- R8: A write is an early write. `dram_we_no` is low only while the row and column strobes are low, and it falls in the same cycle as the column strobes. During that window `dram_dq_oe_o`=1 with the data on `dram_dq_o`. A write produces no `rsp_valid_o`.
- R9: A request to the open row issues only a column cycle, with no new activation. The column strobes stay high for at least `T_CP` cycles between pulses.
- R10: A request to a row other than the open one causes a precharge followed by exactly one activation of the new row.
- R11: A pending refresh closes the open page before new host requests are accepted. A stream of page hits still gets refreshed, and each refresh costs exactly one re-activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_row_i | input | ADDR_W | Row address |
| req_col_i | input | ADDR_W | Column address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| rsp_rdata_o | output | DATA_W | Read data |
| dram_addr_o | output | ADDR_W | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | CAS_W | Column strobes, active low, driven together |
| dram_we_no | output | 1 | Write enable, active low |
| dram_dq_o | output | DATA_W | Data to array |
| dram_dq_oe_o | output | 1 | Data pin drive enable |
| dram_dq_i | input | DATA_W | Data from array |

## Verification
A sequencer stuck in the wrong state, or a stale strobe-age counter, shows up on the strobe pins within one or two cycles. Possible symptoms are a row low period shorter than the active minimum, a column strobe falling too soon after the row strobe, or write enable moving outside its column window. The strobe-timing monitor sees each of these at the next strobe edge. A wrong open-row record shows up at the next request as a missing or surplus activation. It can also show as read data from the wrong location, visible on the following `rsp_valid_o` pulse. A lost refresh request only becomes visible as a refresh gap longer than the interval, so the bench idles with a page open for more than one interval and also runs a long hit stream that spans one.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    S_INIT, S_IDLE, S_ACT, S_COL, S_OPEN, S_PRE, S_RCAS, S_RRAS
  } fpm_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fpm_ref_timer.sv
module fpm_ref_timer #(
  parameter int INIT_CYC = 10000,
  parameter int REF_INT  = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_ack_i,
  output logic pause_done_o,
  output logic ref_req_o
);
  localparam int CW = $clog2(fpm_pkg::imax(INIT_CYC, REF_INT) + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q, req_q, cnt_last;

  // one counter: power-up pause first, then the refresh interval
  assign cnt_last = done_q ? (cnt_q == CW'(REF_INT - 1)) : (cnt_q == CW'(INIT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_last ? '0 : cnt_q + 1'b1;
      if (cnt_last && !done_q) done_q <= 1'b1;
      if (cnt_last && done_q) req_q <= 1'b1;
      else if (ref_ack_i)     req_q <= 1'b0;
    end
  end

  assign pause_done_o = done_q;
  assign ref_req_o    = req_q;
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 144,
  parameter int INIT_REF = 8,
  parameter int T_RP     = 2,
  parameter int T_RAS    = 3,
  parameter int T_RCD    = 1,
  parameter int T_CAS    = 1,
  parameter int T_CP     = 1,
  parameter int T_CSR    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pause_done_i,
  input  logic              ref_req_i,
  output logic              ref_ack_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_row_i,
  input  logic [ADDR_W-1:0] req_col_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              ras_o,
  output logic              cas_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  localparam int TMAX  = imax(imax(imax(T_RP, T_RAS), imax(T_RCD, T_CAS)), imax(T_CP, T_CSR));
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int RW    = $clog2(T_RAS + 1);
  localparam int IW    = $clog2(INIT_REF + 1);

  fpm_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [RW-1:0]     ras_age_q;
  logic [IW-1:0]     init_left_q;
  logic [ADDR_W-1:0] row_q, col_q;
  logic              wr_q, rvalid_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  logic tmr_zero, ras_ok, page_hit, ref_due, accept, row_low;

  assign tmr_zero = (cnt_q == '0);
  assign ras_ok   = (ras_age_q >= RW'(T_RAS - 1));
  assign page_hit = (req_row_i == row_q);
  assign ref_due  = pause_done_i && ((init_left_q != '0) || ref_req_i);
  assign row_low  = (state_q == S_ACT) || (state_q == S_COL) || (state_q == S_OPEN);

  assign req_ready_o = ((state_q == S_IDLE) && pause_done_i && !ref_due) ||
                       ((state_q == S_OPEN) && tmr_zero && !ref_req_i && page_hit);
  assign accept      = req_valid_i && req_ready_o;
  assign ref_ack_o   = (state_q == S_RCAS) && tmr_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_INIT;
      cnt_q       <= '0;
      ras_age_q   <= '0;
      init_left_q <= IW'(INIT_REF);
      row_q       <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      rvalid_q    <= 1'b0;
    end else begin
      cnt_q    <= tmr_zero ? cnt_q : cnt_q - 1'b1;
      rvalid_q <= 1'b0;
      if (!row_low)                      ras_age_q <= '0;
      else if (ras_age_q != RW'(T_RAS))  ras_age_q <= ras_age_q + 1'b1;
      unique case (state_q)
        S_INIT: if (pause_done_i) state_q <= S_IDLE;
        S_IDLE: begin
          if (ref_due) begin
            state_q <= S_RCAS;
            cnt_q   <= CNT_W'(T_CSR - 1);
          end else if (accept) begin
            state_q <= S_ACT;
            cnt_q   <= CNT_W'(T_RCD - 1);
            row_q   <= req_row_i;
            col_q   <= req_col_i;
            wr_q    <= req_write_i;
            wdata_q <= req_wdata_i;
          end
        end
        S_ACT: if (tmr_zero) begin
          state_q <= S_COL;
          cnt_q   <= CNT_W'(T_CAS - 1);
        end
        S_COL: if (tmr_zero) begin
          state_q <= S_OPEN;
          cnt_q   <= CNT_W'(T_CP - 1);
          if (!wr_q) begin
            rdata_q  <= dq_i;
            rvalid_q <= 1'b1;
          end
        end
        S_OPEN: if (tmr_zero) begin
          if (ref_req_i) begin
            if (ras_ok) begin
              state_q <= S_PRE;
              cnt_q   <= CNT_W'(T_RP - 1);
            end
          end else if (accept) begin
            state_q <= S_COL;
            cnt_q   <= CNT_W'(T_CAS - 1);
            col_q   <= req_col_i;
            wr_q    <= req_write_i;
            wdata_q <= req_wdata_i;
          end else if (req_valid_i && ras_ok) begin
            // page miss: close the row, re-activate from idle
            state_q <= S_PRE;
            cnt_q   <= CNT_W'(T_RP - 1);
          end
        end
        S_PRE: if (tmr_zero) state_q <= S_IDLE;
        S_RCAS: if (tmr_zero) begin
          state_q <= S_RRAS;
          cnt_q   <= CNT_W'(T_RAS - 1);
          if (init_left_q != '0) init_left_q <= init_left_q - 1'b1;
        end
        S_RRAS: if (tmr_zero) begin
          state_q <= S_PRE;
          cnt_q   <= CNT_W'(T_RP - 1);
        end
        default: state_q <= S_INIT;
      endcase
    end
  end

  assign ras_o       = row_low || (state_q == S_RRAS);
  assign cas_o       = (state_q == S_COL) || (state_q == S_RCAS) || (state_q == S_RRAS);
  assign we_o        = (state_q == S_COL) && wr_q;
  assign dq_oe_o     = (state_q == S_COL) && wr_q;
  assign addr_o      = (state_q == S_ACT) ? row_q : col_q;
  assign dq_o        = wdata_q;
  assign rsp_valid_o = rvalid_q;
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 144,
  parameter int CAS_W    = 2,
  parameter int INIT_CYC = 10000,
  parameter int INIT_REF = 8,
  parameter int REF_INT  = 780,
  parameter int T_RP     = 2,
  parameter int T_RAS    = 3,
  parameter int T_RCD    = 1,
  parameter int T_CAS    = 1,
  parameter int T_CP     = 1,
  parameter int T_CSR    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_row_i,
  input  logic [ADDR_W-1:0] req_col_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] dram_addr_o,
  output logic              dram_ras_no,
  output logic [CAS_W-1:0]  dram_cas_no,
  output logic              dram_we_no,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [DATA_W-1:0] dram_dq_i
);
  logic pause_done, ref_req, ref_ack;
  logic ras_act, cas_act, we_act;

  fpm_ref_timer #(.INIT_CYC(INIT_CYC), .REF_INT(REF_INT)) i_timer (
    .clk_i, .rst_ni,
    .ref_ack_i   (ref_ack),
    .pause_done_o(pause_done),
    .ref_req_o   (ref_req)
  );

  fpm_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_REF(INIT_REF),
    .T_RP(T_RP), .T_RAS(T_RAS), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_CSR(T_CSR)
  ) i_seq (
    .clk_i, .rst_ni,
    .pause_done_i(pause_done),
    .ref_req_i   (ref_req),
    .ref_ack_o   (ref_ack),
    .req_valid_i, .req_ready_o, .req_write_i, .req_row_i, .req_col_i, .req_wdata_i,
    .rsp_valid_o, .rsp_rdata_o,
    .ras_o  (ras_act),
    .cas_o  (cas_act),
    .we_o   (we_act),
    .addr_o (dram_addr_o),
    .dq_o   (dram_dq_o),
    .dq_oe_o(dram_dq_oe_o),
    .dq_i   (dram_dq_i)
  );

  assign dram_ras_no = ~ras_act;
  assign dram_we_no  = ~we_act;

  for (genvar g = 0; g < CAS_W; g++) begin : g_cas
    assign dram_cas_no[g] = ~cas_act;
  end
endmodule

// File: rtl/fpm_ctrl_chk.sv
module fpm_ctrl_chk #(
  parameter int CAS_W     = 2,
  parameter int INIT_REF  = 8,
  parameter int REF_INT   = 780,
  parameter int T_RP      = 2,
  parameter int T_RAS     = 3,
  parameter int T_RCD     = 1,
  parameter int T_CP      = 1,
  parameter int T_CSR     = 1,
  parameter int REF_SLACK = 16,
  parameter int RASP_MAX  = 5000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             dram_ras_no,
  input logic [CAS_W-1:0] dram_cas_no,
  input logic             dram_we_no
);
  localparam logic [15:0] SAT = 16'hFFFF;

  logic [15:0] ras_lo, ras_hi, cas_lo, cas_hi, cbr_cnt, ref_gap;
  logic        ras_prev, cas_all_lo;

  assign cas_all_lo = (dram_cas_no == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_lo <= '0; ras_hi <= '0; cas_lo <= '0; cas_hi <= '0;
      cbr_cnt <= '0; ref_gap <= '0; ras_prev <= 1'b1;
    end else begin
      ras_prev <= dram_ras_no;
      ras_lo <= dram_ras_no ? '0 : ((ras_lo == SAT) ? SAT : ras_lo + 1'b1);
      ras_hi <= !dram_ras_no ? '0 : ((ras_hi == SAT) ? SAT : ras_hi + 1'b1);
      cas_lo <= dram_cas_no[0] ? '0 : ((cas_lo == SAT) ? SAT : cas_lo + 1'b1);
      cas_hi <= !dram_cas_no[0] ? '0 : ((cas_hi == SAT) ? SAT : cas_hi + 1'b1);
      if (ras_prev && !dram_ras_no && cas_all_lo) begin
        if (cbr_cnt != SAT) cbr_cnt <= cbr_cnt + 1'b1;
        ref_gap <= '0;
      end else if (int'(cbr_cnt) >= INIT_REF && ref_gap != SAT) begin
        ref_gap <= ref_gap + 1'b1;
      end
    end
  end

  AST_RAS_LOW_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_ras_no) |-> int'(ras_lo) >= T_RAS); // R5
  AST_RAS_PRECHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> int'(ras_hi) >= T_RP); // R5
  AST_PAGE_OPEN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ras_lo) < RASP_MAX); // R5
  AST_CBR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_ras_no) && cas_all_lo) |-> (int'(cas_lo) >= T_CSR && dram_we_no && $past(dram_we_no))); // R3
  AST_CAS_TIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dram_cas_no == '0) || (dram_cas_no == '1)); // R3
  AST_RCD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_no[0]) && !dram_ras_no) |-> int'(ras_lo) >= T_RCD); // R6
  AST_CAS_PRECHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no[0]) |-> int'(cas_hi) >= T_CP); // R9
  AST_WE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_we_no |-> (!dram_ras_no && cas_all_lo)); // R8
  AST_EARLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_we_no) |-> $fell(dram_cas_no[0])); // R8
  AST_READY_AFTER_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> int'(cbr_cnt) >= INIT_REF); // R2
  AST_REF_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ref_gap) <= REF_INT + REF_SLACK); // R4
endmodule

bind fpm_ctrl fpm_ctrl_chk #(
  .CAS_W(CAS_W), .INIT_REF(INIT_REF), .REF_INT(REF_INT), .T_RP(T_RP), .T_RAS(T_RAS),
  .T_RCD(T_RCD), .T_CP(T_CP), .T_CSR(T_CSR)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .dram_ras_no(dram_ras_no), .dram_cas_no(dram_cas_no), .dram_we_no(dram_we_no)
);

// File: tb/test_fpm_ctrl.sv
`timescale 1ns/1ps
module test_fpm_ctrl;
  localparam int ADDR_W = 12, DATA_W = 144, CAS_W = 2;
  localparam int INIT_CYC = 10000, INIT_REF = 8, REF_INT = 780, REF_SLACK = 16;
  localparam int T_RP = 2, T_RAS = 3, T_RCD = 1, T_CP = 1, T_CSR = 1, RASP_MAX = 5000;

  typedef struct packed {
    logic        wr;
    logic [11:0] row;
    logic [11:0] col;
    logic [15:0] seed;
  } vec_t;

  localparam vec_t VECS [0:11] = '{
    '{1'b1, 12'h0A5, 12'h001, 16'h1111},
    '{1'b1, 12'h0A5, 12'h002, 16'h2222},
    '{1'b0, 12'h0A5, 12'h001, 16'h1111},
    '{1'b0, 12'h0A5, 12'h002, 16'h2222},
    '{1'b1, 12'h5A0, 12'h005, 16'hC0DE},
    '{1'b0, 12'h5A0, 12'h005, 16'hC0DE},
    '{1'b0, 12'h0A5, 12'h001, 16'h1111},
    '{1'b1, 12'hFFF, 12'hFFF, 16'hFFFF},
    '{1'b0, 12'hFFF, 12'hFFF, 16'hFFFF},
    '{1'b1, 12'h000, 12'h000, 16'h8001},
    '{1'b0, 12'h000, 12'h000, 16'h8001},
    '{1'b0, 12'hFFF, 12'hFFF, 16'hFFFF}
  };

  logic              clk, rst_n;
  logic              req_valid, req_ready, req_write;
  logic [ADDR_W-1:0] req_row, req_col;
  logic [DATA_W-1:0] req_wdata, rsp_rdata, dram_dq_o, dram_dq_i;
  logic              rsp_valid, dram_ras_n, dram_we_n, dram_dq_oe;
  logic [CAS_W-1:0]  dram_cas_n;
  logic [ADDR_W-1:0] dram_addr;

  fpm_ctrl i_fpm_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_row_i(req_row), .req_col_i(req_col), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .dram_addr_o(dram_addr), .dram_ras_no(dram_ras_n), .dram_cas_no(dram_cas_n),
    .dram_we_no(dram_we_n), .dram_dq_o(dram_dq_o), .dram_dq_oe_o(dram_dq_oe),
    .dram_dq_i(dram_dq_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc_n = 0, n_act = 0, n_ref = 0, last_ref = 0, max_gap = 0;
  int v_cbr = 0, v_ras = 0, v_rcd = 0, v_we = 0, v_cp = 0;
  int ras_lo, ras_hi, cas_lo, cas_hi;
  logic p_ras, p_cas0, p_we;
  logic [ADDR_W-1:0] open_row;
  logic [DATA_W-1:0] mem [int];

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // DRAM model and strobe-timing monitor, sampled at the falling clock edge
  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1'b1; p_cas0 = 1'b1; p_we = 1'b1;
      ras_lo = 0; ras_hi = 100000; cas_lo = 0; cas_hi = 100000;
      dram_dq_i = '0; open_row = '0;
    end else begin
      cyc_n++;
      if (dram_cas_n[0] !== dram_cas_n[1]) v_cbr++;
      if (p_ras && !dram_ras_n) begin
        if (ras_hi < T_RP) v_ras++;
        if (!dram_cas_n[0]) begin
          n_ref++;
          if (cas_lo < T_CSR || !dram_we_n || !p_we) v_cbr++;
          if (n_ref > INIT_REF && cyc_n - last_ref > max_gap) max_gap = cyc_n - last_ref;
          last_ref = cyc_n;
        end else begin
          n_act++;
          open_row = dram_addr;
        end
      end
      if (!p_ras && dram_ras_n && ras_lo < T_RAS) v_ras++;
      if (ras_lo == RASP_MAX) v_ras++;
      if (p_cas0 && !dram_cas_n[0]) begin
        if (cas_hi < T_CP) v_cp++;
        if (!dram_ras_n) begin
          if (ras_lo < T_RCD) v_rcd++;
          if (!dram_we_n) begin
            if (!dram_dq_oe) v_we++;
            mem[int'({open_row, dram_addr})] = dram_dq_o;
          end else begin
            if (dram_dq_oe) v_we++;
            dram_dq_i = mem.exists(int'({open_row, dram_addr})) ? mem[int'({open_row, dram_addr})] : '0;
          end
        end
      end
      if (p_we && !dram_we_n && !p_cas0) v_we++;
      if (!dram_we_n && (dram_ras_n || dram_cas_n[0])) v_we++;
      if (dram_ras_n) begin ras_hi++; ras_lo = 0; end else begin ras_lo++; ras_hi = 0; end
      if (dram_cas_n[0]) begin cas_hi++; cas_lo = 0; end else begin cas_lo++; cas_hi = 0; end
      p_ras = dram_ras_n; p_cas0 = dram_cas_n[0]; p_we = dram_we_n;
    end
  end

  int ref_hs;
  task automatic issue(input logic wr, input logic [11:0] row, input logic [11:0] col,
                       input logic [DATA_W-1:0] d, output logic [DATA_W-1:0] rd,
                       output bit got, output int acts);
    int a0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_row = row; req_col = col; req_wdata = d;
    #2;
    while (!req_ready) begin @(negedge clk); #2; end
    a0 = n_act; ref_hs = n_ref;
    @(posedge clk);
    @(negedge clk);
    #2;
    req_valid = 1'b0;
    got = 1'b0; rd = '0;
    for (int i = 0; i < 8; i++) begin
      if (rsp_valid) begin got = 1'b1; rd = rsp_rdata; end
      @(negedge clk); #2;
    end
    acts = n_act - a0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog: actual=hung expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] rd, d;
    bit got;
    int acts, ref_prev, r0, a0, bad_rd;
    logic [11:0] last_row;
    bit first;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_row = '0; req_col = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R1 idle strobes after reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe, req_ready}, 6'b1_11_1_0_0);
    repeat (INIT_CYC - 50) @(negedge clk);
    #2;
    chk("R1 idle strobes late in pause", {dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe, req_ready, n_ref[3:0]}, {6'b1_11_1_0_0, 4'd0});
    while (!req_ready) begin @(negedge clk); #2; end
    chk("R1 ready not before pause", cyc_n >= INIT_CYC, 1);
    chk("R2 refresh count at first ready", n_ref, INIT_REF);

    // vector table
    first = 1'b1; last_row = '0; ref_prev = n_ref;
    for (int k = 0; k < 12; k++) begin
      d = {9{VECS[k].seed}};
      issue(VECS[k].wr, VECS[k].row, VECS[k].col, d, rd, got, acts);
      if (first || VECS[k].row != last_row || ref_hs != ref_prev)
        chk($sformatf("R10 activation count vec %0d", k), acts, 1);
      else
        chk($sformatf("R9 page hit without activation vec %0d", k), acts, 0);
      chk($sformatf("R6 row latched vec %0d", k), open_row, VECS[k].row);
      if (VECS[k].wr) chk($sformatf("R8 no response to write vec %0d", k), got, 0);
      else begin
        chk($sformatf("R7 response strobe vec %0d", k), got, 1);
        chk($sformatf("R7 read data vec %0d", k), rd, d);
      end
      first = 1'b0; last_row = VECS[k].row; ref_prev = ref_hs;
    end

    // idle with open page across a refresh interval
    r0 = n_ref;
    repeat (REF_INT + 40) @(negedge clk);
    #2;
    chk("R4 refresh while idle", n_ref > r0, 1);
    chk("R11 page closed by refresh", dram_ras_n, 1'b1);

    // long hit stream spanning a refresh interval
    issue(1'b1, 12'h123, 12'h000, {9{16'hAAAA}}, rd, got, acts);
    issue(1'b1, 12'h123, 12'h001, {9{16'h5555}}, rd, got, acts);
    r0 = n_ref; a0 = n_act; bad_rd = 0;
    for (int i = 0; i < 150; i++) begin
      issue(1'b0, 12'h123, 12'(i % 2), '0, rd, got, acts);
      if (!got || rd !== ((i % 2) ? {9{16'h5555}} : {9{16'hAAAA}})) bad_rd++;
    end
    chk("R7 hit stream read data errors", bad_rd, 0);
    chk("R11 refresh during hit stream", n_ref > r0, 1);
    chk("R11 one re-activation per refresh", n_act - a0, n_ref - r0);

    chk("R3 refresh ordering violations", v_cbr, 0);
    chk("R4 max refresh gap within limit", (max_gap > 0) && (max_gap <= REF_INT + REF_SLACK), 1);
    chk("R5 row strobe width violations", v_ras, 0);
    chk("R6 row-to-column delay violations", v_rcd, 0);
    chk("R8 early-write violations", v_we, 0);
    chk("R9 column precharge violations", v_cp, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule